// File: doc/BRIEF.md
# Loopback Codec Self-Test Wrapper

This block places a Hamming(7,4) encoder and decoder inside a test shell that runs in one of two states. A single mode input picks the state. In normal operation a 4-bit data word enters the encoder. The resulting 7-bit codeword leaves the block on the code output and also feeds the decoder, which recovers the data word on the data output. In self-test operation a built-in counter replaces the external data word, and the code output is forced to zero so that test traffic stays inside the shell. Each decoded word is compared with the word that was applied two cycles earlier.

A test run starts with a one-cycle start pulse while the block is in self-test. The run applies every 4-bit value once. The shell then raises a done flag and reports through a sticky fail flag whether any decoded word differed from the applied one. Because the expected response is just the applied stimulus, delayed, the checker holds no stored signature. Leaving self-test in the middle of a run aborts the run.

Top module: `codec_selftest_shell`

## Requirements
- R1: After a synchronous active-high reset, code_out, data_out, done and fail are all zero.
- R2: In normal mode (mode=0), code_out shows the codeword of data_in one clock after that data_in is sampled. The codeword bit order is {d4,d3,d2,p3,d1,p2,p1}, from bit 6 down to bit 0, with d1=data_in[0], d2=data_in[1], d3=data_in[2] and d4=data_in[3]. The parity bits are p1=d1^d2^d4, p2=d1^d3^d4 and p3=d2^d3^d4.
- R3: In normal mode, data_out equals the data_in that was sampled two clocks earlier.
- R4: While mode=1, code_out is held at zero.
- R5: A run starts when start=1 and mode=1 are sampled at a clock edge, called edge 0. During the run, data_out shows the values 0, 1, …, 15 in ascending order, and value k is present just after edge k+2.
- R6: done rises just after edge 18 of a run, and not before it. On a healthy codec, fail remains 0.
- R7: done and fail hold their values until the next accepted start, which clears both at edge 0.
- R8: A start pulse while mode=0 is ignored, so done and fail keep their values.
- R9: If mode drops to 0 before a run completes, the run is aborted and done does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 selects normal operation, 1 selects self-test |
| start | input | 1 | Start pulse for a self-test run; takes effect only when mode=1 |
| data_in | input | 4 | Data word to encode in normal mode |
| code_out | output | 7 | Registered codeword; zero while in self-test |
| data_out | output | 4 | Registered decoder output |
| done | output | 1 | Set once the last comparison of a run has completed |
| fail | output | 1 | Sticky mismatch flag for the current run |

## Verification
The assertions assume the following about the inputs:
- start is a single-cycle pulse.
- mode changes only at the same points where the stimulus changes data_in.
- No fault is ever forced onto the codeword path, so the round trip through encoder and decoder always returns the applied word.

The stimulus drives every input on the falling clock edge and gives start only one-cycle pulses. It keeps mode steady for whole phases: random normal-mode traffic, complete runs, one aborted run, and a start given in normal mode.

// File: rtl/cst_pkg.sv
package cst_pkg;

   localparam int unsigned CST_DATA_W = 4;
   localparam int unsigned CST_CODE_W = 7;

   // codeword layout (bit 0 first): p1 p2 d1 p3 d2 d3 d4
   function automatic logic [CST_CODE_W-1:0] ham_encode(input logic [CST_DATA_W-1:0] d);
      logic p1, p2, p3;
      p1 = d[0] ^ d[1] ^ d[3];
      p2 = d[0] ^ d[2] ^ d[3];
      p3 = d[1] ^ d[2] ^ d[3];
      return {d[3], d[2], d[1], p3, d[0], p2, p1};
   endfunction

   // syndrome gives the 1-based position of a single flipped bit
   function automatic logic [CST_DATA_W-1:0] ham_decode(input logic [CST_CODE_W-1:0] c);
      logic [2:0]            syn;
      logic [CST_CODE_W-1:0] fixed;
      syn[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
      syn[1] = c[1] ^ c[2] ^ c[5] ^ c[6];
      syn[2] = c[3] ^ c[4] ^ c[5] ^ c[6];
      fixed  = c;
      if (syn != 3'd0) fixed[syn - 3'd1] = ~c[syn - 3'd1];
      return {fixed[6], fixed[5], fixed[4], fixed[2]};
   endfunction

endpackage

// File: rtl/cst_encoder.sv
module cst_encoder
   import cst_pkg::*;
#(
   parameter int unsigned DATA_W = CST_DATA_W,
   localparam int unsigned CODE_W = CST_CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] word_i,
   output logic [CODE_W-1:0] code_o
);

   generate
      if (DATA_W != CST_DATA_W) begin : g_bad_width
         $error("cst_encoder: only a 4-bit data word is supported");
      end
   endgenerate

   // output isolation register of the encoder
   always_ff @(posedge clk) begin
      if (rst) code_o <= '0;
      else     code_o <= ham_encode(word_i);
   end

endmodule

// File: rtl/cst_decoder.sv
module cst_decoder
   import cst_pkg::*;
#(
   parameter int unsigned DATA_W = CST_DATA_W,
   localparam int unsigned CODE_W = CST_CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] word_o
);

   generate
      if (DATA_W != CST_DATA_W) begin : g_bad_width
         $error("cst_decoder: only a 4-bit data word is supported");
      end
   endgenerate

   // output isolation register of the decoder
   always_ff @(posedge clk) begin
      if (rst) word_o <= '0;
      else     word_o <= ham_decode(code_i);
   end

endmodule

// File: rtl/cst_pattern_gen.sv
module cst_pattern_gen #(
   parameter int unsigned DATA_W   = 4,
   parameter bit          PAT_GRAY = 1'b0,
   localparam logic [DATA_W-1:0] LAST = {DATA_W{1'b1}}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode,
   input  logic              start,
   output logic [DATA_W-1:0] pat_o,
   output logic              pat_valid_o,
   output logic              pat_last_o
);

   logic              running;
   logic [DATA_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!mode) begin
         running <= 1'b0;
      end else if (start) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (running) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) running <= 1'b0;
      end
   end

   generate
      if (PAT_GRAY) begin : g_gray
         assign pat_o = cnt ^ (cnt >> 1);
      end else begin : g_binary
         assign pat_o = cnt;
      end
   endgenerate

   assign pat_valid_o = running;
   assign pat_last_o  = running && (cnt == LAST);

   // R5: an uninterrupted run walks the counter one step per clock
   a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
      (running && mode && !start && cnt != LAST)
      |=> (running && cnt == DATA_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/cst_resp_check.sv
module cst_resp_check #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              flush,
   input  logic              app_valid,
   input  logic              app_last,
   input  logic [DATA_W-1:0] app_word,
   input  logic [DATA_W-1:0] resp_word,
   output logic              done_o,
   output logic              fail_o
);

   // two stages match the encoder and decoder registers
   logic              s1_v, s1_last, s2_v, s2_last;
   logic [DATA_W-1:0] s1_w, s2_w;

   always_ff @(posedge clk) begin
      if (rst || clear || flush) begin
         s1_v    <= 1'b0;
         s1_last <= 1'b0;
         s2_v    <= 1'b0;
         s2_last <= 1'b0;
      end else begin
         s1_v    <= app_valid;
         s1_last <= app_last;
         s2_v    <= s1_v;
         s2_last <= s1_last;
      end
      s1_w <= app_word;
      s2_w <= s1_w;
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         done_o <= 1'b0;
         fail_o <= 1'b0;
      end else if (s2_v) begin
         if (resp_word != s2_w) fail_o <= 1'b1;
         if (s2_last)           done_o <= 1'b1;
      end
   end

   // R6: done only rises right after the final comparison
   a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> $past(s2_v && s2_last));

   // R7: fail is sticky until a new run is accepted
   a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
      (fail_o && !clear) |=> fail_o);

   // R7: done holds until a new run is accepted
   a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
      (done_o && !clear) |=> done_o);

endmodule

// File: rtl/codec_selftest_shell.sv
module codec_selftest_shell
   import cst_pkg::*;
#(
   parameter int unsigned DATA_W   = CST_DATA_W,
   parameter bit          PAT_GRAY = 1'b0,
   localparam int unsigned CODE_W  = CST_CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode,
   input  logic              start,
   input  logic [DATA_W-1:0] data_in,
   output logic [CODE_W-1:0] code_out,
   output logic [DATA_W-1:0] data_out,
   output logic              done,
   output logic              fail
);

   generate
      if (DATA_W != CST_DATA_W) begin : g_bad_width
         $error("codec_selftest_shell: DATA_W must be 4");
      end
   endgenerate

   logic [DATA_W-1:0] pat_word, enc_src;
   logic              pat_valid, pat_last;
   logic [CODE_W-1:0] code_q;

   cst_pattern_gen #(.DATA_W(DATA_W), .PAT_GRAY(PAT_GRAY)) u_pat (
      .clk         (clk),
      .rst         (rst),
      .mode        (mode),
      .start       (start),
      .pat_o       (pat_word),
      .pat_valid_o (pat_valid),
      .pat_last_o  (pat_last)
   );

   // encoder source: external word or shell pattern
   assign enc_src = mode ? pat_word : data_in;

   cst_encoder #(.DATA_W(DATA_W)) u_enc (
      .clk    (clk),
      .rst    (rst),
      .word_i (enc_src),
      .code_o (code_q)
   );

   // the decoder always takes the encoder's registered codeword
   cst_decoder #(.DATA_W(DATA_W)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .code_i (code_q),
      .word_o (data_out)
   );

   // the codeword never leaves the shell during self-test
   assign code_out = mode ? '0 : code_q;

   cst_resp_check #(.DATA_W(DATA_W)) u_chk (
      .clk       (clk),
      .rst       (rst),
      .clear     (mode && start),
      .flush     (!mode),
      .app_valid (pat_valid),
      .app_last  (pat_last),
      .app_word  (pat_word),
      .resp_word (data_out),
      .done_o    (done),
      .fail_o    (fail)
   );

   // R3: the round trip returns the applied word two clocks later
   logic [1:0] settle;
   always_ff @(posedge clk) begin
      if (rst)                 settle <= '0;
      else if (settle != 2'd2) settle <= settle + 2'd1;
   end

   a_r3_round_trip: assert property (@(posedge clk) disable iff (rst)
      (settle == 2'd2) |-> (data_out == $past(enc_src, 2)));

endmodule

// File: tb/codec_selftest_shell_test.sv
module codec_selftest_shell_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst, mode, start;
   logic [3:0] data_in;
   logic [6:0] code_out;
   logic [3:0] data_out;
   logic       done, fail;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   codec_selftest_shell uut (
      .clk(clk), .rst(rst), .mode(mode), .start(start),
      .data_in(data_in), .code_out(code_out), .data_out(data_out),
      .done(done), .fail(fail)
   );

   // parity positions 1,2,4; data at 3,5,6,7 (1-based)
   function automatic logic [6:0] exp_code(input logic [3:0] d);
      logic [6:0] c;
      int         di;
      c  = '0;
      di = 0;
      for (int pos = 1; pos <= 7; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            c[pos-1] = d[di];
            di++;
         end
      end
      for (int pb = 1; pb <= 4; pb = pb * 2) begin
         logic par;
         par = 1'b0;
         for (int pos = 1; pos <= 7; pos++)
            if (((pos & pb) != 0) && (pos != pb)) par ^= c[pos-1];
         c[pb-1] = par;
      end
      return c;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_test();
      @(negedge clk);
      mode  = 1'b1;
      start = 1'b1;
      for (int j = 1; j <= 19; j++) begin
         @(negedge clk);
         start = 1'b0;
         chk("R4 code_out quiet", {1'b0, code_out}, 8'h00);
         if (j == 1) chk("R7 done cleared by start", {7'b0, done}, 8'h00);
         if (j >= 3 && j <= 18) chk("R5 pattern response", {4'b0, data_out}, 8'(j - 3));
         if (j == 18) chk("R6 done not early", {7'b0, done}, 8'h00);
         if (j == 19) begin
            chk("R6 done raised", {7'b0, done}, 8'h01);
            chk("R6 no fail", {7'b0, fail}, 8'h00);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] prev, prev2, nv;
      void'($urandom(32'd4242));
      rst = 1'b1; mode = 1'b0; start = 1'b0; data_in = 4'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 code_out", {1'b0, code_out}, 8'h00);
      chk("R1 data_out", {4'b0, data_out}, 8'h00);
      chk("R1 done", {7'b0, done}, 8'h00);
      chk("R1 fail", {7'b0, fail}, 8'h00);

      // normal traffic: directed corners then random words
      prev = 4'h0; prev2 = 4'h0;
      for (int i = 0; i < 60; i++) begin
         if (i >= 1) chk("R2 codeword", {1'b0, code_out}, {1'b0, exp_code(prev)});
         if (i >= 2) chk("R3 round trip", {4'b0, data_out}, {4'b0, prev2});
         if (i == 0)      nv = 4'h0;
         else if (i == 1) nv = 4'hF;
         else if (i == 2) nv = 4'hA;
         else             nv = 4'($urandom());
         data_in = nv;
         prev2 = prev;
         prev  = nv;
         @(negedge clk);
      end

      run_test();
      repeat (5) begin
         @(negedge clk);
         chk("R7 done held", {7'b0, done}, 8'h01);
         chk("R7 fail held", {7'b0, fail}, 8'h00);
      end

      // start in normal mode must not clear done
      mode = 1'b0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (25) @(negedge clk);
      chk("R8 start ignored in normal", {7'b0, done}, 8'h01);

      // second full run
      run_test();

      // aborted run
      @(negedge clk);
      mode = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      mode = 1'b0;
      repeat (30) begin
         @(negedge clk);
         if (done !== 1'b0) break;
      end
      chk("R9 abort keeps done low", {7'b0, done}, 8'h00);
      chk("R9 abort no fail", {7'b0, fail}, 8'h00);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule